// File: doc/BRIEF.md
# Transmit Buffer Abort Handler

This block keeps the abort bookkeeping for a group of three outgoing message buffers of a CAN controller. Software loads a buffer and claims it by clearing its empty flag. If a more urgent message then needs a slot, software may ask for one of the loaded buffers to be withdrawn by writing 1 to that buffer's abort request bit. The block grants the request only while the buffer is not on the bus. When it grants, it marks the buffer empty, sets the buffer's acknowledge bit and raises the buffer's transmit interrupt.

A message that is already being sent cannot be withdrawn, so its request waits. If the frame then completes, the buffer becomes empty and the acknowledge bit stays clear. If the frame is lost to arbitration or ends in error, the pending abort is granted at that point and no retry is made. From the acknowledge bit, the interrupt handler can tell a withdrawn message from one that was sent.

The transmit engine is represented by three one-cycle strobes (start, done, lost) and a buffer index. Arbitration between buffers, bit timing and framing lie outside this block.

Top module: `can_txab_top`

## Requirements
- R1: After reset every buffer is empty, and all request, acknowledge and interrupt outputs are 0.
- R2: Writing 1 to the request bit of a loaded buffer that is not on the bus shows the request on `abort_req_o` one cycle later. One cycle after that, the abort is granted: the empty flag and the acknowledge bit become 1 and the request bit returns to 0. Several buffers may be granted in the same cycle.
- R3: While a buffer is on the bus it is never aborted. Its request stays set and its empty flag stays 0 until the transmission ends.
- R4: If a buffer with a pending request finishes sending (done strobe), its empty flag becomes 1, its acknowledge bit stays 0 and its request bit clears, one cycle after the strobe.
- R5: If a buffer with a pending request loses arbitration or hits an error (lost strobe), the abort is granted one cycle after the strobe: the empty flag becomes 1, the acknowledge bit becomes 1 and the request bit clears.
- R6: A lost strobe on a buffer without a pending request leaves the buffer loaded and takes it off the bus. A later request is then granted within the normal two cycles.
- R7: A request written to a buffer whose empty flag is 1 is ignored, and its request bit stays 0.
- R8: Writing 1 to the empty-clear bit of an empty buffer clears its empty flag and its acknowledge bit one cycle later. The write has no effect on a buffer that is already loaded.
- R9: Each bit of `tx_irq_o` equals that buffer's empty flag ANDed with its bit of `irq_en_i`, in the same cycle.
- R10: If a start strobe names a buffer in the same cycle that its abort is granted, the abort wins: the buffer is not put on the bus, and a following done strobe leaves its acknowledge bit at 1.
- R11: `tx_buf_i` holds the buffer number in binary (0, 1 or 2). A start strobe affects only that buffer, and only if it is loaded. Done and lost strobes act on whichever buffer is currently on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort_req_set_i | input | 3 | Write-1 pulses that request an abort, one bit per buffer |
| empty_clr_i | input | 3 | Write-1 pulses that clear the empty flag, one bit per buffer |
| irq_en_i | input | 3 | Transmit interrupt enable, one bit per buffer |
| tx_start_i | input | 1 | Engine strobe: the buffer named by tx_buf_i goes onto the bus |
| tx_buf_i | input | 2 | Binary number of the buffer named by the start strobe |
| tx_done_i | input | 1 | Engine strobe: the frame on the bus completed successfully |
| tx_lost_i | input | 1 | Engine strobe: the frame on the bus lost arbitration or failed |
| abort_req_o | output | 3 | Pending abort request bits |
| abort_ack_o | output | 3 | Abort acknowledge bits |
| empty_o | output | 3 | Buffer-empty flags |
| tx_irq_o | output | 3 | Per-buffer transmit interrupts |

## Verification
Each input is applied at a falling edge and held for one rising edge. Every state result (request, empty and acknowledge bits) is therefore sampled at the next falling edge, one cycle after its stimulus. The exception is a fresh abort request, which needs two cycles: one to register the request and one to grant it. The interrupt outputs have no register stage and are checked in the same half cycle as the flags they follow. Where a request must stay pending while its buffer is on the bus, the outputs are sampled over several cycles before the ending strobe, to confirm that nothing moves.

// File: rtl/can_txab_pkg.sv
package can_txab_pkg;

   // upper bound accepted for the buffer count parameter
   localparam int unsigned TXAB_MAX_BUF = 8;

   // strobes from the transmit engine, grouped
   typedef struct packed {
      logic start;
      logic done;
      logic lost;
   } txab_evt_t;

   function automatic int unsigned txab_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/can_txab_decode.sv
module can_txab_decode #(
   parameter int unsigned NBUF = 3,
   parameter int unsigned IDXW = 2
) (
   input  logic [IDXW-1:0] idx_i,
   output logic [NBUF-1:0] sel_o
);

   initial begin
      assert (NBUF <= (1 << IDXW))
         else $error("can_txab_decode: index too narrow for NBUF");
   end

   for (genvar g = 0; g < NBUF; g++) begin : g_sel
      assign sel_o[g] = (idx_i == IDXW'(g));
   end

endmodule

// File: rtl/can_txab_slot.sv
module can_txab_slot
   import can_txab_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sel_i,
   input  txab_evt_t evt_i,
   input  logic      req_set_i,
   input  logic      empty_clr_i,
   output logic      req_o,
   output logic      ack_o,
   output logic      empty_o,
   output logic      busy_o
);

   logic req_q, ack_q, empty_q, busy_q;
   logic grant_idle, end_ok, end_bad, grant_lost;
   logic set_empty, set_ack, start_hit, claim;

   // abort of a loaded buffer that is not on the bus
   assign grant_idle = req_q & ~empty_q & ~busy_q;
   // end of this buffer's frame
   assign end_ok     = busy_q & evt_i.done;
   assign end_bad    = busy_q & evt_i.lost & ~evt_i.done;
   assign grant_lost = end_bad & req_q;

   assign set_empty  = grant_idle | end_ok | grant_lost;
   assign set_ack    = grant_idle | grant_lost;
   // a grant in this cycle beats a start for the same buffer
   assign start_hit  = evt_i.start & sel_i & ~empty_q & ~grant_idle;
   assign claim      = empty_clr_i & empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         ack_q   <= 1'b0;
         empty_q <= 1'b1;
         busy_q  <= 1'b0;
      end else begin
         if (set_empty)                 empty_q <= 1'b1;
         else if (claim)                empty_q <= 1'b0;

         if (set_ack)                   ack_q <= 1'b1;
         else if (claim)                ack_q <= 1'b0;

         if (set_empty)                 req_q <= 1'b0;
         else if (req_set_i & ~empty_q) req_q <= 1'b1;

         if (end_ok | end_bad)          busy_q <= 1'b0;
         else if (start_hit)            busy_q <= 1'b1;
      end
   end

   assign req_o   = req_q;
   assign ack_o   = ack_q;
   assign empty_o = empty_q;
   assign busy_o  = busy_q;

   // R2
   ack_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> empty_q);

   // R3
   no_abort_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !evt_i.done && !evt_i.lost) |=> (!empty_q && busy_q));

   // R4
   sent_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && evt_i.done) |=> (empty_o && !ack_o && !req_o));

   // R5
   lost_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && evt_i.lost && !evt_i.done && req_q) |=> (empty_q && ack_q));

   // R7
   empty_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_q && !req_q) |=> !req_q);

   // R2
   req_cleared_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(empty_q) |-> !req_q);

endmodule

// File: rtl/can_txab_irq.sv
module can_txab_irq #(
   parameter int unsigned NBUF    = 3,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NBUF-1:0] empty_i,
   input  logic [NBUF-1:0] en_i,
   output logic [NBUF-1:0] irq_o
);

   if (IRQ_REG) begin : g_reg
      logic [NBUF-1:0] irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= '0;
         else        irq_q <= empty_i & en_i;
      end
      assign irq_o = irq_q;

      // R9
      irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ##1 (irq_o == $past(empty_i & en_i)));
   end else begin : g_comb
      assign irq_o = empty_i & en_i;
   end

endmodule

// File: rtl/can_txab_top.sv
module can_txab_top
   import can_txab_pkg::*;
#(
   parameter int unsigned NBUF    = 3,
   parameter bit          IRQ_REG = 1'b0,
   localparam int unsigned IDXW   = txab_idx_w(NBUF)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NBUF-1:0] abort_req_set_i,
   input  logic [NBUF-1:0] empty_clr_i,
   input  logic [NBUF-1:0] irq_en_i,
   input  logic            tx_start_i,
   input  logic [IDXW-1:0] tx_buf_i,
   input  logic            tx_done_i,
   input  logic            tx_lost_i,
   output logic [NBUF-1:0] abort_req_o,
   output logic [NBUF-1:0] abort_ack_o,
   output logic [NBUF-1:0] empty_o,
   output logic [NBUF-1:0] tx_irq_o
);

   initial begin
      assert (NBUF >= 1 && NBUF <= TXAB_MAX_BUF)
         else $error("can_txab_top: NBUF out of range");
   end

   txab_evt_t       evt;
   logic [NBUF-1:0] sel, busy;

   assign evt.start = tx_start_i;
   assign evt.done  = tx_done_i;
   assign evt.lost  = tx_lost_i;

   can_txab_decode #(.NBUF(NBUF), .IDXW(IDXW)) i_decode (
      .idx_i (tx_buf_i),
      .sel_o (sel)
   );

   for (genvar g = 0; g < NBUF; g++) begin : g_slot
      can_txab_slot i_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .sel_i       (sel[g]),
         .evt_i       (evt),
         .req_set_i   (abort_req_set_i[g]),
         .empty_clr_i (empty_clr_i[g]),
         .req_o       (abort_req_o[g]),
         .ack_o       (abort_ack_o[g]),
         .empty_o     (empty_o[g]),
         .busy_o      (busy[g])
      );
   end

   can_txab_irq #(.NBUF(NBUF), .IRQ_REG(IRQ_REG)) i_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .empty_i (empty_o),
      .en_i    (irq_en_i),
      .irq_o   (tx_irq_o)
   );

   // R11
   one_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(busy));

   // R11
   bus_buffer_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((busy & empty_o) == '0));

endmodule

// File: tb/test_can_txab_top.sv
module test_can_txab_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] req_set = '0, clr = '0, en = '0;
   logic          start = 1'b0, done = 1'b0, lost = 1'b0;
   logic [1:0]    bufi = '0;
   logic [NB-1:0] req_o, ack_o, empty_o, irq_o;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_txab_top i_can_txab_top (
      .clk(clk), .rst_n(rst_n),
      .abort_req_set_i(req_set), .empty_clr_i(clr), .irq_en_i(en),
      .tx_start_i(start), .tx_buf_i(bufi), .tx_done_i(done), .tx_lost_i(lost),
      .abort_req_o(req_o), .abort_ack_o(ack_o), .empty_o(empty_o), .tx_irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_clr(input logic [NB-1:0] m);
      clr = m; tick(1); clr = '0;
   endtask
   task automatic do_req(input logic [NB-1:0] m);
      req_set = m; tick(1); req_set = '0;
   endtask
   task automatic do_start(input logic [1:0] b);
      start = 1'b1; bufi = b; tick(1); start = 1'b0;
   endtask
   task automatic do_done();
      done = 1'b1; tick(1); done = 1'b0;
   endtask
   task automatic do_lost();
      lost = 1'b1; tick(1); lost = 1'b0;
   endtask

   task automatic t_reset();
      en = 3'b111;
      chk("R1 empty", empty_o, 3'b111);
      chk("R1 ack", ack_o, 3'b000);
      chk("R1 req", req_o, 3'b000);
      en = 3'b000; #1;
      chk("R1 irq", irq_o, 3'b000);
   endtask

   task automatic t_idle_abort();
      do_clr(3'b011);
      chk("R8 claim", empty_o, 3'b100);
      do_req(3'b011);
      chk("R2 req shown", req_o, 3'b011);
      chk("R2 not yet empty", empty_o, 3'b100);
      tick(1);
      chk("R2 empty", empty_o, 3'b111);
      chk("R2 ack", ack_o, 3'b011);
      chk("R2 req clear", req_o, 3'b000);
      do_clr(3'b011);
      chk("R8 ack cleared", ack_o, 3'b000);
      chk("R8 empty cleared", empty_o, 3'b100);
      do_clr(3'b001);
      chk("R8 loaded unaffected", empty_o, 3'b100);
   endtask

   task automatic t_busy_then_done();
      // buffers 0 and 1 loaded from previous task
      do_start(2'd1);
      do_req(3'b010);
      tick(3);
      chk("R3 req held", req_o, 3'b010);
      chk("R3 still loaded", empty_o, 3'b100);
      chk("R11 others untouched", ack_o, 3'b000);
      do_done();
      chk("R4 empty", empty_o, 3'b110);
      chk("R4 ack clear", ack_o, 3'b000);
      chk("R4 req clear", req_o, 3'b000);
   endtask

   task automatic t_lost();
      do_start(2'd0);
      do_lost();
      chk("R6 still loaded", empty_o, 3'b110);
      chk("R6 no ack", ack_o, 3'b000);
      do_req(3'b001);
      tick(1);
      chk("R6 grant after lost", {ack_o[0], empty_o[0]}, 3'b011);
      do_clr(3'b001);
      do_start(2'd0);
      do_req(3'b001);
      tick(2);
      chk("R3 held while on bus", empty_o, 3'b110);
      do_lost();
      chk("R5 empty", empty_o, 3'b111);
      chk("R5 ack", ack_o, 3'b001);
      chk("R5 req", req_o, 3'b000);
   endtask

   task automatic t_empty_req();
      do_clr(3'b001);
      do_req(3'b110);
      chk("R7 ignored", req_o, 3'b000);
      tick(1);
      chk("R7 ack unchanged", ack_o, 3'b000);
   endtask

   task automatic t_irq();
      en = 3'b101; #1;
      chk("R9 irq masked", irq_o, 3'b100);
      en = 3'b111; #1;
      chk("R9 irq all", irq_o, 3'b110);
      en = 3'b000;
   endtask

   task automatic t_race();
      // buffer 2 empty: start must be ignored (R11)
      do_start(2'd2);
      do_clr(3'b100);
      do_req(3'b100);
      tick(1);
      chk("R11 start on empty ignored", {ack_o[2], empty_o[2]}, 2'b11);
      do_clr(3'b100);
      do_req(3'b100);
      start = 1'b1; bufi = 2'd2; tick(1); start = 1'b0;
      chk("R10 grant wins", {ack_o[2], empty_o[2]}, 2'b11);
      do_done();
      chk("R10 done ignored", ack_o, 3'b100);
      do_start(2'd0);
      do_done();
      chk("R11 done on bus buffer", empty_o, 3'b111);
      chk("R11 acks", ack_o, 3'b100);
   endtask

   initial begin
      fork
         begin
            tick(3);
            rst_n = 1'b1;
            tick(1);
            t_reset();
            t_idle_abort();
            t_busy_then_done();
            t_lost();
            t_empty_req();
            t_irq();
            t_race();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual expired expected finish");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule